// File: doc/BRIEF.md
# Half-Duplex Transmit Turn-Off and Receive Clamp Controller

This controller runs the transmit side of a modem around the request-to-send line. When the terminal raises request-to-send, the transmitter is enabled and the line-conditioning sequence runs. Ready-for-sending is granted only when the turn-on generator reports that training has finished.

When request-to-send drops, ready-for-sending is withdrawn at once and a fixed two-part turn-off runs:
- The first segment keeps the transmitter on and selects scrambled ones behind the last user bits.
- The second segment is silent.

A new request raised while turn-off is running is held off until the silent segment ends. Both segment lengths are counted in millisecond ticks.

On a 2-wire half-duplex line the receive outputs are clamped whenever the station is sending. Received data is forced to 1 and carrier detect is forced OFF. An optional hold-off keeps this clamp on for a programmable number of millisecond ticks after request-to-send falls. This stops the local echo from reaching the terminal.

Top module: `hdx_turnoff_ctl`

## Requirements
- R1: After reset the controller is idle: tx_en_o, ones_sel_o and cts_o are 0.
- R2: From idle, rts_i = 1 at a clock edge moves the controller to training, and tx_en_o is 1 from that edge. cts_o stays 0.
- R3: cts_o goes to 1 only at an edge where train_done_i = 1 and rts_i = 1 while training. train_done_i while idle has no effect.
- R4: cts_o returns to 0 at the first clock edge at which rts_i = 0.
- R5: The first turn-off segment starts at the edge at which rts_i is seen low. It holds tx_en_o = 1 and ones_sel_o = 1 for SEG_A_MS ticks of ms_tick_i (default 8). The segment ends at the edge of the last of those ticks.
- R6: The second turn-off segment holds tx_en_o = 0 and ones_sel_o = 0 for SEG_B_MS ticks (default 20). At the edge of the last of those ticks the controller returns to idle, or enters hold-off.
- R7: rts_i = 1 during either turn-off segment has no effect on tx_en_o or cts_o. If rts_i is still 1 when turn-off ends, training starts at the next clock edge.
- R8: With two_wire_i = 1, rxd_o = 1 and dcd_o = 0 in every cycle with rts_i = 1, and also in the cycle in which rts_i first reads 0. With two_wire_i = 0, rxd_o and dcd_o equal rxd_raw_i and dcd_raw_i.
- R9: With two_wire_i = 1 and holdoff_en_i = 1, the clamp of R8 holds for HOLD_MS ticks after the edge at which rts_i fell (default 150). It releases at the edge of the last of those ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rts_i | input | 1 | Request-to-send from the terminal |
| two_wire_i | input | 1 | 1 = 2-wire half-duplex line, enables receive clamping |
| holdoff_en_i | input | 1 | 1 = extend the clamp after request-to-send falls |
| train_done_i | input | 1 | One-cycle pulse: turn-on training has finished |
| rxd_raw_i | input | 1 | Received data from the demodulator |
| dcd_raw_i | input | 1 | Carrier detect from the level detector |
| ms_tick_i | input | 1 | One-cycle pulse once per millisecond |
| tx_en_o | output | 1 | Transmitter enable |
| ones_sel_o | output | 1 | Select scrambled ones as transmit source |
| rxd_o | output | 1 | Received data to the terminal, clamped |
| dcd_o | output | 1 | Carrier detect to the terminal, clamped |
| cts_o | output | 1 | Ready-for-sending |

## Verification
tx_en_o, ones_sel_o and cts_o come from the state register. They change at the first rising edge that sees the causing input or tick. rxd_o and dcd_o follow rts_i and the raw inputs in the same cycle, and follow the hold-off timer from the edge of its last tick. The bench changes inputs only after a rising edge. It presents one tick per step and samples one time unit after the next rising edge, so each result is read in the cycle it is due. Segment lengths are checked on both sides of the boundary tick: one tick before it and at it.

// File: rtl/hdx_pkg.sv
`timescale 1ns/1ps
package hdx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_TRAIN    = 3'd1,
        ST_DATA     = 3'd2,
        ST_TURNOFF_A = 3'd3,
        ST_TURNOFF_B = 3'd4,
        ST_HOLDOFF  = 3'd5
    } ctl_state_e;

    typedef struct packed {
        ctl_state_e st;
        logic       rts_prev;
    } ctl_regs_s;

endpackage

// File: rtl/hdx_seg_timer.sv
`timescale 1ns/1ps
module hdx_seg_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         tick_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)       cnt_d = '0;
        else if (tick_i) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/hdx_hold_timer.sv
`timescale 1ns/1ps
module hdx_hold_timer #(
    parameter int LOAD_VAL = 150,
    localparam int W = $clog2(LOAD_VAL + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic tick_i,
    output logic busy_o
);
    logic [W-1:0] rem_d, rem_q;

    always_comb begin
        rem_d = rem_q;
        if (load_i)                        rem_d = W'(LOAD_VAL);
        else if (tick_i && rem_q != '0)    rem_d = rem_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rem_q <= '0;
        else        rem_q <= rem_d;
    end

    assign busy_o = (rem_q != '0);
endmodule

// File: rtl/hdx_rx_clamp.sv
`timescale 1ns/1ps
module hdx_rx_clamp (
    input  logic clamp_i,
    input  logic rxd_raw_i,
    input  logic dcd_raw_i,
    output logic rxd_o,
    output logic dcd_o
);
    always_comb begin
        rxd_o = clamp_i ? 1'b1 : rxd_raw_i;
        dcd_o = clamp_i ? 1'b0 : dcd_raw_i;
    end
endmodule

// File: rtl/hdx_turnoff_ctl.sv
`timescale 1ns/1ps
module hdx_turnoff_ctl #(
    parameter int SEG_A_MS = 8,
    parameter int SEG_B_MS = 20,
    parameter int HOLD_MS  = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rts_i,
    input  logic two_wire_i,
    input  logic holdoff_en_i,
    input  logic train_done_i,
    input  logic rxd_raw_i,
    input  logic dcd_raw_i,
    input  logic ms_tick_i,
    output logic tx_en_o,
    output logic ones_sel_o,
    output logic rxd_o,
    output logic dcd_o,
    output logic cts_o
);
    import hdx_pkg::*;

    localparam int SEG_MAX = (SEG_A_MS > SEG_B_MS) ? SEG_A_MS : SEG_B_MS;
    localparam int SEG_W   = $clog2(SEG_MAX + 1);
    localparam logic [SEG_W-1:0] A_LAST = SEG_W'(SEG_A_MS - 1);
    localparam logic [SEG_W-1:0] B_LAST = SEG_W'(SEG_B_MS - 1);

    ctl_regs_s        ctl_d, ctl_q;
    logic [SEG_W-1:0] seg_cnt;
    logic             seg_clr;
    logic             hold_busy;
    logic             rts_fall;
    logic             clamp;

    assign rts_fall = ctl_q.rts_prev && !rts_i;

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.rts_prev = rts_i;
        case (ctl_q.st)
            ST_IDLE: begin
                if (rts_i) ctl_d.st = ST_TRAIN;
            end
            ST_TRAIN: begin
                if (!rts_i)            ctl_d.st = ST_TURNOFF_A;
                else if (train_done_i) ctl_d.st = ST_DATA;
            end
            ST_DATA: begin
                if (!rts_i) ctl_d.st = ST_TURNOFF_A;
            end
            ST_TURNOFF_A: begin
                if (ms_tick_i && seg_cnt == A_LAST) ctl_d.st = ST_TURNOFF_B;
            end
            ST_TURNOFF_B: begin
                if (ms_tick_i && seg_cnt == B_LAST)
                    ctl_d.st = (two_wire_i && holdoff_en_i && hold_busy)
                               ? ST_HOLDOFF : ST_IDLE;
            end
            ST_HOLDOFF: begin
                if (rts_i)           ctl_d.st = ST_TRAIN;
                else if (!hold_busy) ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
        seg_clr = (ctl_d.st != ctl_q.st) ||
                  !(ctl_q.st == ST_TURNOFF_A || ctl_q.st == ST_TURNOFF_B);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, rts_prev: 1'b0};
        else        ctl_q <= ctl_d;
    end

    hdx_seg_timer #(.W(SEG_W)) u_seg (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (seg_clr),
        .tick_i (ms_tick_i),
        .cnt_o  (seg_cnt)
    );

    hdx_hold_timer #(.LOAD_VAL(HOLD_MS)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (rts_fall),
        .tick_i (ms_tick_i),
        .busy_o (hold_busy)
    );

    assign clamp = two_wire_i &&
                   (rts_i || ctl_q.rts_prev || (holdoff_en_i && hold_busy));

    hdx_rx_clamp u_clamp (
        .clamp_i   (clamp),
        .rxd_raw_i (rxd_raw_i),
        .dcd_raw_i (dcd_raw_i),
        .rxd_o     (rxd_o),
        .dcd_o     (dcd_o)
    );

    assign tx_en_o    = (ctl_q.st == ST_TRAIN) || (ctl_q.st == ST_DATA) ||
                        (ctl_q.st == ST_TURNOFF_A);
    assign ones_sel_o = (ctl_q.st == ST_TURNOFF_A);
    assign cts_o      = (ctl_q.st == ST_DATA);
endmodule

// File: rtl/hdx_turnoff_chk.sv
`timescale 1ns/1ps
module hdx_turnoff_chk (
    input logic clk,
    input logic rst_n,
    input logic rts_i,
    input logic two_wire_i,
    input logic train_done_i,
    input logic rxd_raw_i,
    input logic dcd_raw_i,
    input logic tx_en_o,
    input logic ones_sel_o,
    input logic rxd_o,
    input logic dcd_o,
    input logic cts_o
);
    p_cts_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cts_o) |-> ($past(rts_i) && $past(train_done_i)));

    p_cts_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_o && !rts_i) |=> !cts_o);

    p_ones_with_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ones_sel_o |-> tx_en_o);

    p_silent_after_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ones_sel_o) |-> !tx_en_o);

    p_no_grant_in_turnoff_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ones_sel_o |=> !cts_o);

    p_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (two_wire_i && rts_i) |-> (rxd_o && !dcd_o));

    p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !two_wire_i |-> (rxd_o == rxd_raw_i && dcd_o == dcd_raw_i));
endmodule

bind hdx_turnoff_ctl hdx_turnoff_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rts_i        (rts_i),
    .two_wire_i   (two_wire_i),
    .train_done_i (train_done_i),
    .rxd_raw_i    (rxd_raw_i),
    .dcd_raw_i    (dcd_raw_i),
    .tx_en_o      (tx_en_o),
    .ones_sel_o   (ones_sel_o),
    .rxd_o        (rxd_o),
    .dcd_o        (dcd_o),
    .cts_o        (cts_o)
);

// File: tb/tb_hdx_turnoff_ctl.sv
`timescale 1ns/1ps
module tb_hdx_turnoff_ctl;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rts = 1'b0, two = 1'b0, hen = 1'b0, td = 1'b0;
    logic rxr = 1'b0, dcr = 1'b1, tick = 1'b0;
    logic tx_en, ones, rxd, dcd, cts;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdx_turnoff_ctl dut (
        .clk(clk), .rst_n(rst_n), .rts_i(rts), .two_wire_i(two),
        .holdoff_en_i(hen), .train_done_i(td), .rxd_raw_i(rxr),
        .dcd_raw_i(dcr), .ms_tick_i(tick), .tx_en_o(tx_en),
        .ones_sel_o(ones), .rxd_o(rxd), .dcd_o(dcd), .cts_o(cts)
    );

    // fields: rts two hen td rxr dcr | tx ones rxd dcd cts
    localparam logic [10:0] VEC [9] = '{
        {6'b010001, 5'b00010},   // idle
        {6'b010101, 5'b00010},   // train_done while idle: ignored (R3)
        {6'b110001, 5'b10100},   // turn on (R2), clamp (R8)
        {6'b110001, 5'b10100},   // still training
        {6'b110101, 5'b10101},   // grant (R3)
        {6'b100001, 5'b10011},   // 4-wire pass-through (R8)
        {6'b010001, 5'b11010},   // rts off: segment A, cts off (R4 R5)
        {6'b110101, 5'b11100},   // rts during turn-off ignored (R7)
        {6'b010001, 5'b11010}
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic tk);
        @(negedge clk);
        tick = tk;
        @(posedge clk);
        #1;
        tick = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rts = 0; two = 0; hen = 0; td = 0; rxr = 0; dcr = 1; tick = 0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic go_data();
        rts = 1; step(1'b0);
        td = 1;  step(1'b0);
        td = 0;
    endtask

    initial begin
        do_reset();
        step(1'b0);
        check("R1 tx_en", tx_en, 1'b0);
        check("R1 ones_sel", ones, 1'b0);
        check("R1 cts", cts, 1'b0);

        foreach (VEC[i]) begin
            {rts, two, hen, td, rxr, dcr} = VEC[i][10:5];
            step(1'b0);
            check($sformatf("v%0d tx_en R2 R5 R7", i), tx_en, VEC[i][4]);
            check($sformatf("v%0d ones_sel R5", i), ones, VEC[i][3]);
            check($sformatf("v%0d rxd R8", i), rxd, VEC[i][2]);
            check($sformatf("v%0d dcd R8", i), dcd, VEC[i][1]);
            check($sformatf("v%0d cts R3 R4", i), cts, VEC[i][0]);
        end

        // segment timing and deferred request, 4-wire
        do_reset();
        go_data();
        check("R3 grant", cts, 1'b1);
        rts = 0; step(1'b0);
        check("R4 cts off", cts, 1'b0);
        for (int k = 1; k < 8; k++) step(1'b1);
        check("R5 A before last tick tx", tx_en, 1'b1);
        check("R5 A before last tick ones", ones, 1'b1);
        step(1'b1);
        check("R5 A ends tx", tx_en, 1'b0);
        check("R6 B ones", ones, 1'b0);
        rts = 1;
        for (int k = 1; k < 20; k++) step(1'b1);
        check("R7 B ignores rts tx", tx_en, 1'b0);
        check("R7 B ignores rts cts", cts, 1'b0);
        step(1'b1);
        check("R6 B end idle tx", tx_en, 1'b0);
        step(1'b0);
        check("R7 deferred turn on", tx_en, 1'b1);
        check("R7 no early cts", cts, 1'b0);
        td = 1; step(1'b0); td = 0;
        check("R3 grant after retrain", cts, 1'b1);

        // hold-off, 2-wire
        do_reset();
        two = 1; hen = 1; rxr = 0; dcr = 1;
        go_data();
        rts = 0; step(1'b0);
        for (int k = 1; k < 150; k++) begin
            step(1'b1);
            if (k == 28) check("R6 silent during hold-off", tx_en, 1'b0);
        end
        check("R9 clamp held rxd", rxd, 1'b1);
        check("R9 clamp held dcd", dcd, 1'b0);
        step(1'b1);
        check("R9 clamp released rxd", rxd, 1'b0);
        check("R9 clamp released dcd", dcd, 1'b1);
        rts = 1; step(1'b0);
        check("R2 turn on after hold-off", tx_en, 1'b1);

        // no hold-off: clamp ends after rts falls
        do_reset();
        two = 1; hen = 0;
        go_data();
        rts = 0; #1;
        check("R8 clamp in fall cycle", rxd, 1'b1);
        step(1'b0);
        check("R8 released without hold-off", rxd, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule